// File: doc/BRIEF.md
# NAND Flash Command Cycle Sequencer

This block turns one control word into the complete run of bus cycles for an 8-bit parallel NAND flash device. Software first sets up the byte, address, data and timing registers. It then writes a control word with the start bit set. The sequencer asserts the chosen chip enable and waits out a setup time. It then runs each phase whose enable bit is set and skips the rest. The possible phases are:

- a first command latch cycle;
- a run of address latch cycles;
- a second command latch cycle;
- a wait on the device's ready line;
- a programmed data transfer of one to four bytes.

The whole run has a fixed order, and one bit of the control word changes it. When the last phase ends, the block drops `busy` and pulses `done` for one clock.

Strobe widths and gaps come from a 32-bit timing word. Each field value is stretched by a fixed number of clocks that depends on the field. Received bytes are packed into `rx_data` least significant byte first. A control write of all zeros stops any operation in progress at once.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset all chip enables are high, both strobes are high, both latch lines, `bus_oe`, `busy` and `done` are low.
- R2: A control write with bit 31 set while idle starts an operation. From the next clock until the end, `chip_en_n` equals the inverse of control bits [15:8]; while idle it is all ones.
- R3: With bit 24 clear, the phase order is: first command (bit 30, `cmd1_byte` with `cmd_latch` high), then address (bit 29, `addr_latch` high, count = bits [2:0] + 1, bytes taken low byte first from `addr_lo` and then `addr_hi`), then second command (bit 25, `cmd2_byte`), then ready wait (bit 16), then data. A phase whose bit is clear is skipped.
- R4: With bit 24 set, the data phase moves ahead of the second command, and the ready wait follows the second command.
- R5: The data phase runs when bit 28 and either bit 27 or bit 26 is set. With bit 27 set it transmits (bits [21:20] + 1) bytes from `pio_tx`, low byte first. The first byte's write strobe is preceded by a gap of adl + 3 clocks after the previous write-high time.
- R6: With bit 27 clear, the data phase receives bytes with read strobes. Each byte is sampled on the last clock of its strobe-low time and placed into `rx_data` low byte first. Unused byte lanes read zero. The gap before the first read strobe is rr + 3 clocks when a ready wait came before it in the same operation, and whr + 1 clocks otherwise.
- R7: Each write strobe is low for wp + 1 clocks and high for wh + 1 clocks. The byte value and the latch lines hold steady while the strobe is low.
- R8: Each read strobe is low for rp + 1 clocks and high for rh + 1 clocks.
- R9: The chip enable leads the first strobe by cs + 2 clocks.
- R10: The ready wait first idles wb + 1 clocks. It then holds until `bus_ready`, passed through a two-stage synchronizer, reads high.
- R11: `done` is high for exactly one clock, in the first idle clock after the last phase, and `busy` is low in that clock.
- R12: A control write of zero returns the block to idle on the next clock, releases the chip enables and raises no `done`.
- R13: A nonzero control write while busy has no effect on the running operation.
- R14: The two strobes are never low together, and the two latch lines are never high together.

Timing word layout, from least significant bit upwards:

| Field | Bits |
|---|---|
| wp | [3:0] |
| rp | [7:4] |
| wh | [9:8] |
| rh | [11:10] |
| cs | [13:12] |
| wb | [19:16] |
| whr | [23:20] |
| adl | [27:24] |
| rr | [31:28] |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Control word write strobe |
| cmd_wdata | input | 32 | Control word |
| cmd1_byte | input | 8 | First command opcode |
| cmd2_byte | input | 8 | Second command opcode |
| addr_lo | input | 32 | Address bytes 0 to 3 |
| addr_hi | input | 32 | Address bytes 4 to 7 |
| pio_tx | input | 32 | Transmit data bytes |
| timing | input | 32 | Timing field word |
| bus_ready | input | 1 | Device ready line, high when ready |
| bus_din | input | 8 | Data from the device |
| rx_data | output | 32 | Assembled receive bytes |
| chip_en_n | output | 8 | Active-low chip enables |
| cmd_latch | output | 1 | Command latch enable |
| addr_latch | output | 1 | Address latch enable |
| wr_strobe_n | output | 1 | Active-low write strobe |
| rd_strobe_n | output | 1 | Active-low read strobe |
| bus_dout | output | 8 | Byte driven to the device |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The sequencer is exercised with these control words:

- A full page-read style word with every phase but transmit, five address bytes, four received bytes and the ready line held low for a while. This shows the default phase order, strobe widths, the setup lead and the wait.
- A program style word with the after-data bit set. This tells the two orderings apart and exposes the address-to-data gap.
- A word with only the second command enabled, and a word with eight address cycles. These separate skipping from ordering and show the switch from the low to the high address register.
- A short receive with no wait. This isolates the write-to-read gap and the zero fill of unused lanes.
- An abort during the wait, and a stray nonzero write during a run. These show that only a zero word interrupts.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int B_CMD1  = 30;
  localparam int B_ADDR  = 29;
  localparam int B_PIO   = 28;
  localparam int B_TX    = 27;
  localparam int B_RX    = 26;
  localparam int B_CMD2  = 25;
  localparam int B_AFTER = 24;
  localparam int B_WAIT  = 16;
  localparam int B_GO    = 31;
  localparam int NSLOT   = 5;

  typedef enum logic [2:0] {
    PH_CMD1, PH_ADDR, PH_CMD2, PH_WAIT, PH_DATA, PH_NONE
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_WLO, S_WHI, S_GAP, S_RDY, S_RLO, S_RHI
  } st_e;

  typedef struct packed {
    logic [3:0] rr;
    logic [3:0] adl;
    logic [3:0] whr;
    logic [3:0] wb;
    logic [1:0] rsv;
    logic [1:0] cs;
    logic [1:0] rh;
    logic [1:0] wh;
    logic [3:0] rp;
    logic [3:0] wp;
  } tim_t;

  // Phase held in each slot of the sequence; the after bit swaps the tail.
  function automatic phase_e slot_phase(input logic [2:0] s, input logic after);
    case (s)
      3'd0:    return PH_CMD1;
      3'd1:    return PH_ADDR;
      3'd2:    return after ? PH_DATA : PH_CMD2;
      3'd3:    return after ? PH_CMD2 : PH_WAIT;
      3'd4:    return after ? PH_WAIT : PH_DATA;
      default: return PH_NONE;
    endcase
  endfunction

  function automatic logic phase_on(input phase_e p, input logic [31:0] c);
    case (p)
      PH_CMD1: return c[B_CMD1];
      PH_ADDR: return c[B_ADDR];
      PH_CMD2: return c[B_CMD2];
      PH_WAIT: return c[B_WAIT];
      PH_DATA: return c[B_PIO] & (c[B_TX] | c[B_RX]);
      default: return 1'b0;
    endcase
  endfunction

  // First enabled slot at or after 'from'; NSLOT when none is left.
  function automatic logic [2:0] find_slot(input logic [2:0] from, input logic [31:0] c);
    logic [2:0] r;
    r = 3'(NSLOT);
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (3'(i) >= from && phase_on(slot_phase(3'(i), c[B_AFTER]), c))
        r = 3'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/nand_pulse_timer.sv
module nand_pulse_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (load)
      cnt_n = load_val;
    else if (cnt != '0)
      cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nand_rdy_sync.sv
module nand_rdy_sync #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [N-1:0] sr;

  generate
    if (N == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[N-2:0], d};
      end
    end
  endgenerate

  assign q = sr[N-1];
endmodule

// File: rtl/nand_byte_pick.sv
module nand_byte_pick #(
  parameter int NB = 4,
  parameter int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [8*NB-1:0] bytes,
  input  logic [IW-1:0]   idx,
  output logic [7:0]      b
);
  assign b = bytes[8*idx +: 8];
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int TMR_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic [7:0]  cmd1_byte,
  input  logic [7:0]  cmd2_byte,
  input  logic [31:0] addr_lo,
  input  logic [31:0] addr_hi,
  input  logic [31:0] pio_tx,
  input  logic [31:0] timing,
  input  logic        bus_ready,
  input  logic [7:0]  bus_din,
  output logic [31:0] rx_data,
  output logic [7:0]  chip_en_n,
  output logic        cmd_latch,
  output logic        addr_latch,
  output logic        wr_strobe_n,
  output logic        rd_strobe_n,
  output logic [7:0]  bus_dout,
  output logic        bus_oe,
  output logic        busy,
  output logic        done
);
  import nand_seq_pkg::*;

  localparam logic [TMR_W-1:0] OFS_SETUP = TMR_W'(1);
  localparam logic [TMR_W-1:0] OFS_LONG  = TMR_W'(2);

  tim_t   tim;
  st_e    st, st_n;
  phase_e cur_ph, nxt_ph;
  logic [2:0]  pos, pos_n, bcnt, bcnt_n, adv_from, nxt;
  logic [31:0] cmd_q, rx_q;
  logic        done_q, done_n;
  logic        tmr_ld, tmr_zero, rdy_s;
  logic [TMR_W-1:0] tmr_val;
  logic        start, abort, adv, last_byte, cmd_ld, rx_clr, rx_cap, data_tx;
  logic [7:0]  addr_b, tx_b;
  logic        unused_bits;

  assign tim     = tim_t'(timing);
  assign start   = cmd_wr && cmd_wdata[B_GO] && (st == S_IDLE);
  assign abort   = cmd_wr && (cmd_wdata == 32'd0);
  assign data_tx = cmd_q[B_TX];
  assign cur_ph  = slot_phase(pos, cmd_q[B_AFTER]);
  assign adv_from = (st == S_SETUP) ? 3'd0 : pos + 3'd1;
  assign nxt     = find_slot(adv_from, cmd_q);
  assign nxt_ph  = slot_phase(nxt, cmd_q[B_AFTER]);

  always_comb begin
    case (cur_ph)
      PH_ADDR: last_byte = (bcnt == cmd_q[2:0]);
      PH_DATA: last_byte = (bcnt == {1'b0, cmd_q[21:20]});
      default: last_byte = 1'b1;
    endcase
  end

  nand_pulse_timer #(.W(TMR_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero)
  );

  nand_rdy_sync #(.N(SYNC_N)) i_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ready), .q(rdy_s)
  );

  nand_byte_pick #(.NB(8)) i_addr_pick (
    .bytes({addr_hi, addr_lo}), .idx(bcnt), .b(addr_b)
  );

  nand_byte_pick #(.NB(4)) i_tx_pick (
    .bytes(pio_tx), .idx(bcnt[1:0]), .b(tx_b)
  );

  // Next-state logic
  always_comb begin
    st_n    = st;
    pos_n   = pos;
    bcnt_n  = bcnt;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    done_n  = 1'b0;
    cmd_ld  = 1'b0;
    rx_clr  = 1'b0;
    rx_cap  = 1'b0;
    adv     = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        st_n = S_SETUP; cmd_ld = 1'b1; rx_clr = 1'b1;
        tmr_ld = 1'b1; tmr_val = TMR_W'(tim.cs) + OFS_SETUP;
      end
      S_SETUP: if (tmr_zero) adv = 1'b1;
      S_WLO: if (tmr_zero) begin
        st_n = S_WHI; tmr_ld = 1'b1; tmr_val = TMR_W'(tim.wh);
      end
      S_WHI: if (tmr_zero) begin
        if (last_byte) adv = 1'b1;
        else begin
          bcnt_n = bcnt + 3'd1; st_n = S_WLO;
          tmr_ld = 1'b1; tmr_val = TMR_W'(tim.wp);
        end
      end
      S_GAP: if (tmr_zero) begin
        if (cur_ph == PH_WAIT) st_n = S_RDY;
        else if (data_tx) begin
          st_n = S_WLO; tmr_ld = 1'b1; tmr_val = TMR_W'(tim.wp);
        end else begin
          st_n = S_RLO; tmr_ld = 1'b1; tmr_val = TMR_W'(tim.rp);
        end
      end
      S_RDY: if (rdy_s) adv = 1'b1;
      S_RLO: if (tmr_zero) begin
        rx_cap = 1'b1; st_n = S_RHI; tmr_ld = 1'b1; tmr_val = TMR_W'(tim.rh);
      end
      S_RHI: if (tmr_zero) begin
        if (last_byte) adv = 1'b1;
        else begin
          bcnt_n = bcnt + 3'd1; st_n = S_RLO;
          tmr_ld = 1'b1; tmr_val = TMR_W'(tim.rp);
        end
      end
      default: st_n = S_IDLE;
    endcase

    if (adv) begin
      pos_n  = nxt;
      bcnt_n = 3'd0;
      case (nxt_ph)
        PH_CMD1, PH_CMD2, PH_ADDR: begin
          st_n = S_WLO; tmr_ld = 1'b1; tmr_val = TMR_W'(tim.wp);
        end
        PH_WAIT: begin
          st_n = S_GAP; tmr_ld = 1'b1; tmr_val = TMR_W'(tim.wb);
        end
        PH_DATA: begin
          st_n = S_GAP; tmr_ld = 1'b1;
          if (data_tx)
            tmr_val = TMR_W'(tim.adl) + OFS_LONG;
          else if (cmd_q[B_WAIT] && !cmd_q[B_AFTER])
            tmr_val = TMR_W'(tim.rr) + OFS_LONG;
          else
            tmr_val = TMR_W'(tim.whr);
        end
        default: begin
          st_n = S_IDLE; done_n = 1'b1;
        end
      endcase
    end

    if (abort) begin
      st_n   = S_IDLE;
      done_n = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pos    <= 3'd0;
      bcnt   <= 3'd0;
      done_q <= 1'b0;
    end else begin
      st     <= st_n;
      pos    <= pos_n;
      bcnt   <= bcnt_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_ld) cmd_q <= cmd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_q <= '0;
    else if (rx_clr) rx_q <= '0;
    else if (rx_cap) rx_q[8*bcnt[1:0] +: 8] <= bus_din;
  end

  // Pin decode
  logic wr_ph;
  assign wr_ph       = (st == S_WLO) || (st == S_WHI);
  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign rx_data     = rx_q;
  assign chip_en_n   = busy ? ~cmd_q[15:8] : 8'hFF;
  assign wr_strobe_n = (st != S_WLO);
  assign rd_strobe_n = (st != S_RLO);
  assign cmd_latch   = wr_ph && ((cur_ph == PH_CMD1) || (cur_ph == PH_CMD2));
  assign addr_latch  = wr_ph && (cur_ph == PH_ADDR);
  assign bus_oe      = wr_ph;

  always_comb begin
    case (cur_ph)
      PH_CMD1: bus_dout = cmd1_byte;
      PH_CMD2: bus_dout = cmd2_byte;
      PH_ADDR: bus_dout = addr_b;
      default: bus_dout = tx_b;
    endcase
  end

  assign unused_bits = ^{tim.rsv, cmd_q[31], cmd_q[23:22], cmd_q[19:17], cmd_q[7:3]};

  // R14
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_strobe_n && !rd_strobe_n));
  // R14
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_latch && addr_latch));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_wdata == 32'd0) |=> (!busy && !done));
  // R2
  idle_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (chip_en_n == 8'hFF));
  // R7
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_strobe_n && !abort) |=> ($stable(bus_dout) && $stable(cmd_latch) && $stable(addr_latch)));
  // R10
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RDY && !rdy_s) |=> (st == S_RDY || st == S_IDLE));
endmodule

// File: tb/test_nand_cmd_seq.sv
`timescale 1ns/1ps
module test_nand_cmd_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cmd_wr, bus_ready;
  logic [31:0] cmd_wdata, addr_lo, addr_hi, pio_tx, timing, rx_data;
  logic [7:0]  cmd1_byte, cmd2_byte, bus_din, chip_en_n, bus_dout;
  logic        cmd_latch, addr_latch, wr_strobe_n, rd_strobe_n, bus_oe, busy, done;

  nand_cmd_seq i_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd1_byte(cmd1_byte), .cmd2_byte(cmd2_byte), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .pio_tx(pio_tx), .timing(timing), .bus_ready(bus_ready), .bus_din(bus_din),
    .rx_data(rx_data), .chip_en_n(chip_en_n), .cmd_latch(cmd_latch), .addr_latch(addr_latch),
    .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .busy(busy), .done(done)
  );

  int checks = 0, errors = 0, cyc = 0;

  // Bus monitor state
  logic       ev_cle[16], ev_ale[16];
  logic [7:0] ev_io[16];
  int         ev_low[16], ev_pre[16], rd_low[8], rd_pre[8], rd_gap[8];
  int         n_ev, n_rd, done_cnt, done_bad, overlap;
  int         we_run, hi_run, re_run, since_we, re_hi, cur_pre;
  logic       pwe, pre_n, lat_cle, lat_ale;
  logic [7:0] lat_io, ce_seen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_ev = 0; n_rd = 0; done_cnt = 0; done_bad = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_din = 8'h00; pwe = 1'b1; pre_n = 1'b1; hi_run = 0; since_we = 0;
      re_hi = 0; we_run = 0; re_run = 0; overlap = 0;
    end else begin
      if ((!wr_strobe_n && !rd_strobe_n) || (cmd_latch && addr_latch)) overlap++;
      if (!wr_strobe_n && pwe) begin
        we_run = 0; cur_pre = hi_run; ce_seen = chip_en_n;
      end
      if (!wr_strobe_n) begin
        we_run++; lat_cle = cmd_latch; lat_ale = addr_latch; lat_io = bus_dout;
      end
      if (wr_strobe_n && !pwe) begin
        if (n_ev < 16) begin
          ev_cle[n_ev] = lat_cle; ev_ale[n_ev] = lat_ale; ev_io[n_ev] = lat_io;
          ev_low[n_ev] = we_run; ev_pre[n_ev] = cur_pre;
        end
        n_ev++; hi_run = 1; since_we = 1;
      end else begin
        if (wr_strobe_n && chip_en_n != 8'hFF) hi_run++;
        if (wr_strobe_n && rd_strobe_n) since_we++;
      end
      if (chip_en_n == 8'hFF) hi_run = 0;
      if (!rd_strobe_n && pre_n) begin
        if (n_rd < 8) begin rd_pre[n_rd] = since_we; rd_gap[n_rd] = re_hi; end
        re_run = 0;
        bus_din = 8'hC0 + 8'(n_rd);
      end
      if (!rd_strobe_n) re_run++;
      if (rd_strobe_n && !pre_n) begin
        if (n_rd < 8) rd_low[n_rd] = re_run;
        n_rd++; re_hi = 1;
      end else if (rd_strobe_n) re_hi++;
      if (done) begin done_cnt++; if (busy) done_bad++; end
      pwe = wr_strobe_n; pre_n = rd_strobe_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL R11 watchdog actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic launch(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0; cmd_wdata = 32'd0;
  endtask

  task automatic wait_ev(input int n);
    for (int t = 0; t < 3000 && n_ev < n; t++) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    chk(req, 32'(done_cnt), 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 idle pins", {chip_en_n, wr_strobe_n, rd_strobe_n, cmd_latch, addr_latch, bus_oe, busy, done},
        {8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
  endtask

  // Page read: cmd1, 5 address, cmd2, wait, 4-byte receive
  task automatic t_read();
    logic [7:0] exp_io[7] = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h30};
    int bad_io = 0, bad_low = 0, bad_pre = 0, bad_rd = 0;
    cmd1_byte = 8'h00; cmd2_byte = 8'h30; bus_ready = 1'b0; clear_mon();
    launch(32'hF6310404);
    wait_ev(7);
    repeat (30) @(negedge clk);
    chk("R10 held by ready low", {28'd0, 1'b0, busy, 2'(n_rd)}, {28'd0, 1'b0, 1'b1, 2'd0});
    launch(32'hC0000100);
    repeat (5) @(negedge clk);
    chk("R13 stray write events", 32'(n_ev), 32'd7);
    chk("R13 stray write chip enable", {24'd0, chip_en_n}, 32'h000000FB);
    bus_ready = 1'b1;
    wait_done("R11 read done count");
    for (int i = 0; i < 7; i++) begin
      if (ev_io[i] !== exp_io[i] || ev_cle[i] !== (i == 0 || i == 6) || ev_ale[i] !== (i > 0 && i < 6))
        bad_io++;
      if (ev_low[i] != 3) bad_low++;
      if (i > 0 && ev_pre[i] != 2) bad_pre++;
    end
    chk("R3 read sequence bytes and latches", 32'(bad_io), 32'd0);
    chk("R7 write low widths", 32'(bad_low), 32'd0);
    chk("R7 write high widths", 32'(bad_pre), 32'd0);
    chk("R9 setup lead", 32'(ev_pre[0]), 32'd3);
    chk("R2 chip enable during op", {24'd0, ce_seen}, 32'h000000FB);
    chk("R6 read byte count", 32'(n_rd), 32'd4);
    chk("R6 assembled data", rx_data, 32'hC3C2C1C0);
    for (int i = 0; i < 4; i++) begin
      if (rd_low[i] != 4) bad_rd++;
      if (i > 0 && rd_gap[i] != 3) bad_rd++;
    end
    chk("R8 read strobe widths", 32'(bad_rd), 32'd0);
    chk("R11 busy low with done", 32'(done_bad), 32'd0);
    chk("R2 chip enable released", {24'd0, chip_en_n}, 32'h000000FF);
  endtask

  // Program: cmd1, 2 address, 3-byte transmit, cmd2 after data, wait
  task automatic t_write();
    logic [7:0] exp_io[7] = '{8'h80, 8'h11, 8'h22, 8'hD0, 8'hC1, 8'hB2, 8'h10};
    int bad = 0;
    cmd1_byte = 8'h80; cmd2_byte = 8'h10; pio_tx = 32'hA3B2C1D0; bus_ready = 1'b1; clear_mon();
    launch(32'hFB210101);
    wait_done("R11 write done count");
    chk("R4 write event count", 32'(n_ev), 32'd7);
    for (int i = 0; i < 7; i++)
      if (ev_io[i] !== exp_io[i] || ev_cle[i] !== (i == 0 || i == 6) || ev_ale[i] !== (i == 1 || i == 2))
        bad++;
    chk("R4 data before second command", 32'(bad), 32'd0);
    chk("R5 address to data gap", 32'(ev_pre[3]), 32'd6);
    chk("R5 no reads on transmit", 32'(n_rd), 32'd0);
    chk("R2 chip enable select 0", {24'd0, ce_seen}, 32'h000000FE);
  endtask

  task automatic t_skip();
    cmd2_byte = 8'h70; clear_mon();
    launch(32'h82008000);
    wait_done("R11 skip done count");
    chk("R3 single event", 32'(n_ev), 32'd1);
    chk("R3 second command only", {22'd0, ev_cle[0], ev_ale[0], ev_io[0]}, {22'd0, 1'b1, 1'b0, 8'h70});
    chk("R9 setup lead skip", 32'(ev_pre[0]), 32'd3);
    chk("R2 chip enable select 7", {24'd0, ce_seen}, 32'h0000007F);
  endtask

  task automatic t_addr8();
    int bad = 0;
    clear_mon();
    launch(32'hA0000107);
    wait_done("R11 address done count");
    chk("R3 eight address cycles", 32'(n_ev), 32'd8);
    for (int i = 0; i < 8; i++)
      if (ev_io[i] !== 8'((i + 1) * 8'h11) || ev_ale[i] !== 1'b1 || ev_cle[i] !== 1'b0) bad++;
    chk("R3 address bytes low first across registers", 32'(bad), 32'd0);
  endtask

  task automatic t_rx_short();
    cmd1_byte = 8'h90; clear_mon();
    launch(32'hD4000100);
    wait_done("R11 short read done count");
    chk("R6 one byte received", 32'(n_rd), 32'd1);
    chk("R6 unused lanes zero", rx_data, 32'h000000C0);
    chk("R6 gap without wait", 32'(rd_pre[0]), 32'd7);
  endtask

  task automatic t_abort();
    cmd1_byte = 8'h00; cmd2_byte = 8'h30; bus_ready = 1'b0; clear_mon();
    launch(32'hF6310404);
    wait_ev(7);
    repeat (5) @(negedge clk);
    launch(32'h00000000);
    chk("R12 idle after abort", {23'd0, busy, chip_en_n}, {23'd0, 1'b0, 8'hFF});
    bus_ready = 1'b1;
    repeat (40) @(negedge clk);
    chk("R12 no done after abort", 32'(done_cnt), 32'd0);
    chk("R12 no reads after abort", 32'(n_rd), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = 32'd0; bus_ready = 1'b1;
    cmd1_byte = 8'h00; cmd2_byte = 8'h00; pio_tx = 32'd0;
    addr_lo = 32'h44332211; addr_hi = 32'h88776655;
    timing = 32'h21421932;
    n_ev = 0; n_rd = 0; done_cnt = 0; done_bad = 0; overlap = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_skip();
    t_addr8();
    t_rx_short();
    t_abort();
    t_skip();
    chk("R14 strobe and latch exclusivity", 32'(overlap), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule